// File: doc/BRIEF.md
# Slow-Device Wait-State Generator

This block stretches CPU bus cycles that target a slow memory, such as a boot ROM, so that the rest of the system can keep its full clock rate. It runs on the CPU clock and watches the slow device's active-low chip select. When a new access to that device begins, it holds the CPU ready line low for a programmed number of whole clock periods, from zero to two. Each stalled period gives the device one more full clock period to respond. Address setup and data setup time are not charged again for an extended cycle.

The chip select must be settled before the rising clock edge that starts the access. The block only decides at rising edges, so any glitch between edges has no effect. Reads and writes are stalled in the same way, which is correct for a CPU that honours ready during writes. The ready line can be bidirectional, because the CPU pulls it low itself when it waits for an interrupt. For that reason the block gives an output-enable as well as the level it wants to drive. The enable is asserted only while a stall is in progress, and the line is released at all other times.

Top module: `mws_wait_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the block is idle after that edge: `rdy_drv` is 1, `rdy_oe` is 0, and there is no pending stall.
- R2: An access starts at a rising edge where `cs_n` is sampled 0 and was sampled 1 (or reset was active) at the previous edge.
- R3: A wait count of 1 at the start edge makes `rdy_drv` 0 for exactly one clock period after that edge. It is 1 again after the next edge.
- R4: A wait count of 2 makes `rdy_drv` 0 for exactly two clock periods after the start edge.
- R5: A wait count of 0 never pulls `rdy_drv` low.
- R6: A wait count of 3 is treated as the maximum of 2, so the stall lasts two periods.
- R7: While `cs_n` stays 0 after the stall has ended, `rdy_drv` stays 1 and no further stall is inserted.
- R8: At any edge where `cs_n` is sampled 1, a stall in progress is cancelled and `rdy_drv` is 1 after that edge.
- R9: `rdy_oe` is 1 exactly in the periods where `rdy_drv` is 0, so the line is released whenever no stall is active.
- R10: The wait count is sampled only at the start edge. Changing `wait_cnt` during a stall does not change its length.
- R11: After `cs_n` returns to 1 and then to 0 again, a new access is stalled again by the count sampled at its start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all decisions are made at its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select of the slow device, valid before the rising edge |
| wait_cnt | input | WAIT_W | Number of wait periods per access; 0 to 2, and 3 is treated as 2 |
| rdy_drv | output | 1 | Level to drive on the CPU ready line; 0 while stalling |
| rdy_oe | output | 1 | Drive enable for the ready line; 1 only while stalling |

## Verification
The assertions check several rules at every clock edge. `rdy_oe` must always mirror a low `rdy_drv`. A start with a zero count must never stall, and a start with a nonzero count must stall at once. An idle select must release the line, a held select must never trigger a second stall, and no run of low ready may be longer than the maximum count. Some behaviour can only be seen in the bench's scenarios. These are the exact stall length for each count, the saturation of a count of 3, the count staying fixed while `wait_cnt` changes mid-stall, and re-arming after the select toggles. The bench mixes directed sequences with seeded random select and count patterns.

// File: rtl/mws_pkg.sv
package mws_pkg;

  // Per-edge view of the slow-device select.
  typedef struct packed {
    logic active;  // select sampled active at this edge
    logic start;   // first active edge of a new access
  } mws_evt_t;

endpackage

// File: rtl/mws_access_detect.sv
module mws_access_detect
  import mws_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n,
  output mws_evt_t evt
);

  logic cs_act;
  logic cs_prev_q;

  assign cs_act = ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= cs_act;
    end
  end

  always_comb begin
    evt.active = cs_act;
    evt.start  = cs_act & ~cs_prev_q & ~rst;
  end

endmodule

// File: rtl/mws_wait_counter.sv
module mws_wait_counter
  import mws_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  mws_evt_t         evt,
  input  logic [CNT_W-1:0] load_val,
  output logic             stall_d
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (!evt.active) begin
      rem_d = '0;
    end else if (evt.start) begin
      rem_d = load_val;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
    end
  end

  assign stall_d = (rem_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/mws_rdy_driver.sv
module mws_rdy_driver (
  input  logic clk,
  input  logic rst,
  input  logic stall_d,
  output logic rdy_drv,
  output logic rdy_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_drv <= 1'b1;
      rdy_oe  <= 1'b0;
    end else begin
      rdy_drv <= ~stall_d;
      rdy_oe  <= stall_d;
    end
  end

endmodule

// File: rtl/mws_wait_gen.sv
module mws_wait_gen
  import mws_pkg::*;
#(
  parameter int MAX_WAIT = 2,
  parameter int WAIT_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              rdy_drv,
  output logic              rdy_oe
);

  localparam int CNT_W = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);
  localparam int CMP_W = (WAIT_W > CNT_W) ? WAIT_W : CNT_W;

  mws_evt_t         evt;
  logic [CNT_W-1:0] load_val;
  logic [CMP_W-1:0] req_wide;
  logic             stall_d;

  assign req_wide = CMP_W'(wait_cnt);
  assign load_val = (req_wide > CMP_W'(MAX_WAIT)) ? CNT_W'(MAX_WAIT)
                                                  : CNT_W'(req_wide);

  mws_access_detect u_detect (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .evt  (evt)
  );

  mws_wait_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .load_val (load_val),
    .stall_d  (stall_d)
  );

  mws_rdy_driver u_drive (
    .clk     (clk),
    .rst     (rst),
    .stall_d (stall_d),
    .rdy_drv (rdy_drv),
    .rdy_oe  (rdy_oe)
  );

endmodule

// File: rtl/mws_wait_gen_chk.sv
module mws_wait_gen_chk #(
  parameter int MAX_WAIT = 2,
  parameter int WAIT_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic              rdy_drv,
  input logic              rdy_oe
);

  localparam int RUN_W = $clog2(MAX_WAIT + 2) + 1;

  logic             prev_low_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_low_q <= 1'b0;
      run_q      <= '0;
    end else begin
      prev_low_q <= ~cs_n;
      if (rdy_drv) run_q <= '0;
      else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (rdy_drv && !rdy_oe));

  // R9
  oe_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_oe == !rdy_drv));

  // R5
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !prev_low_q && wait_cnt == '0) |=> rdy_drv);

  // R3
  start_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !prev_low_q && wait_cnt != '0) |=> !rdy_drv);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (rdy_drv && !rdy_oe));

  // R7
  no_restall_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && prev_low_q && rdy_drv) |=> rdy_drv);

  // R4
  stall_len_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q <= RUN_W'(MAX_WAIT)));

endmodule

bind mws_wait_gen mws_wait_gen_chk #(.MAX_WAIT(MAX_WAIT), .WAIT_W(WAIT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .wait_cnt (wait_cnt),
  .rdy_drv  (rdy_drv),
  .rdy_oe   (rdy_oe)
);

// File: tb/mws_wait_gen_tb.sv
`timescale 1ns/1ps
module mws_wait_gen_tb;

  localparam int MAX_WAIT = 2;
  localparam int WAIT_W   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_n = 1'b1;
  logic [WAIT_W-1:0] wait_cnt = '0;
  logic              rdy_drv;
  logic              rdy_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  bit m_prev_act = 0;
  int m_rem = 0;

  always #2 clk = ~clk;

  mws_wait_gen #(.MAX_WAIT(MAX_WAIT), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wait_cnt(wait_cnt),
    .rdy_drv(rdy_drv), .rdy_oe(rdy_oe)
  );

  function automatic int clamp_wait(input int w);
    return (w > MAX_WAIT) ? MAX_WAIT : w;
  endfunction

  function automatic string pick_tag(input bit r, input bit act, input bit strt, input int w);
    if (r) return "R1";
    if (!act) return "R8";
    if (strt) begin
      if (w == 0) return "R5";
      if (w == 1) return "R3";
      if (w == 2) return "R4";
      return "R6";
    end
    return "R7";
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, got, exp, $time);
    end
  endtask

  // Drive at a falling edge, step the reference on the rising edge,
  // then compare at the next falling edge.
  task automatic cycle(input bit r, input bit csn, input int w, input string tag_in);
    bit act, strt;
    string tag;
    rst = r; cs_n = csn; wait_cnt = WAIT_W'(w);
    @(posedge clk);
    act  = !csn;
    strt = act && !m_prev_act;
    tag  = (tag_in != "") ? tag_in : pick_tag(r, act, strt, w);
    if (r) begin
      m_prev_act = 0; m_rem = 0;
    end else begin
      if (!act) m_rem = 0;
      else if (strt) m_rem = clamp_wait(w);
      else if (m_rem > 0) m_rem--;
      m_prev_act = act;
    end
    @(negedge clk);
    check(tag, rdy_drv, (m_rem == 0), "rdy_drv");
    check("R9", rdy_oe, (m_rem != 0), "rdy_oe");
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: reset, even with select active
    cycle(1, 1, 2, "R1");
    cycle(1, 0, 2, "R1");
    cycle(0, 1, 0, "");
    // R3: one wait, then R7 held select without repeat
    cycle(0, 0, 1, "R3");
    cycle(0, 0, 1, "R3");
    cycle(0, 0, 1, "R7");
    cycle(0, 0, 2, "R7");
    cycle(0, 1, 0, "R8");
    // R4: two waits
    cycle(0, 0, 2, "R4");
    cycle(0, 0, 2, "R4");
    cycle(0, 0, 2, "R4");
    cycle(0, 1, 2, "R8");
    // R5: zero waits
    cycle(0, 0, 0, "R5");
    cycle(0, 0, 0, "R5");
    cycle(0, 1, 0, "R5");
    // R6: count 3 saturates to 2
    cycle(0, 0, 3, "R6");
    cycle(0, 0, 3, "R6");
    cycle(0, 0, 3, "R6");
    cycle(0, 1, 3, "R6");
    // R10: count changed during stall
    cycle(0, 0, 1, "R10");
    cycle(0, 1, 2, "R10");
    cycle(0, 0, 2, "R10");
    cycle(0, 0, 0, "R10");
    cycle(0, 0, 0, "R10");
    // R8: cancel mid-stall
    cycle(0, 1, 2, "R8");
    cycle(0, 0, 2, "R8");
    cycle(0, 1, 2, "R8");
    // R11: rapid re-arm
    cycle(0, 0, 1, "R11");
    cycle(0, 1, 1, "R11");
    cycle(0, 0, 1, "R11");
    cycle(0, 0, 1, "R11");
    // R2: first active edge right after reset starts an access
    cycle(1, 0, 1, "R1");
    cycle(0, 0, 1, "R2");
    cycle(0, 0, 1, "R2");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      bit r   = ($urandom % 100) < 2;
      bit csn = ($urandom % 100) < 35;
      int w   = $urandom % 4;
      cycle(r, csn, w, "");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule